// File: doc/BRIEF.md
# CAM Match Port Access Controller

This block lets a simple host master run a lookup in an external content-addressable memory through the memory's synchronous 32-bit match port. The host raises a single request with a key. The controller then runs two bus phases on the memory side. In the first phase it drives the key onto the memory data bus and pulses an active-low start strobe, which latches the key and begins the search. In the second phase it asserts an active-low output enable and samples the result word. Between the two phases it stalls while the memory's active-low match-complete input stays high.

The host receives the result word and a one-cycle done pulse. The active-low match-successful input is placed in the word's most significant bit, so a cleared MSB means a hit and a set MSB means a miss. The memory's status inputs are treated as pulled up: high reads as "still searching" and "no match". A programmable limit bounds the wait. If the search never completes, the access is abandoned and an error is reported alongside the done pulse.

Top module: `cam_match_ctrl`

## Requirements
- R1: After synchronous reset, host_ready is 1, host_done and host_err are 0, host_result is 0, cam_start_n and cam_oe_n are 1, and cam_dq_oe is 0.
- R2: A host_req seen at a clock edge while host_ready is 1 captures host_key. During the following cycle (write phase), cam_start_n is 0 for exactly that one cycle and cam_dq_out equals the captured key.
- R3: cam_dq_oe is 1 only in the write-phase cycle. It is never 1 while cam_oe_n is 0.
- R4: After the write phase the controller waits for as long as cam_mc_n is 1. host_ready is 0 from the write phase until the cycle after the done pulse.
- R5: When cam_mc_n is sampled 0 during the wait, the next cycle is the read phase. In that cycle cam_oe_n is 0 for exactly one cycle.
- R6: At the clock edge that ends the read phase, host_result becomes {cam_ms_n, cam_dq_in[30:0]}. An MSB of 0 marks a hit and an MSB of 1 marks a miss.
- R7: host_done is 1 for exactly the one cycle after the read phase (or after an abort), and host_ready is 1 in the next cycle.
- R8: If cam_mc_n is still 1 in the wait cycle whose index (counted from 0) equals wait_limit, the access aborts without a read phase. host_done and host_err are then both 1 for one cycle, and host_result becomes 32'h8000_0000.
- R9: host_req is ignored while host_ready is 0. No further start strobe occurs and the captured key is not replaced.
- R10: If cam_mc_n is 0 in the same wait cycle in which the limit is reached, the completion wins. The read phase follows and host_err stays 0.
- R11: host_result keeps its last value while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory match port |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host match request |
| host_key | input | 32 | Key to search for |
| wait_limit | input | 16 | Index of the last tolerated wait cycle |
| host_ready | output | 1 | High when a new request can be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Timeout flag, valid with host_done |
| host_result | output | 32 | Result word, MSB is 0 on a hit |
| cam_dq_out | output | 32 | Key driven toward the memory |
| cam_dq_oe | output | 1 | Enable for the data bus driver |
| cam_dq_in | input | 32 | Data returned by the memory |
| cam_start_n | output | 1 | Active-low latch/start-search strobe |
| cam_oe_n | output | 1 | Active-low memory output enable |
| cam_mc_n | input | 1 | Active-low match complete (high = searching) |
| cam_ms_n | input | 1 | Active-low match successful |

## Verification
The hardest case to reach from the ports is the wait cycle where match-complete falls at the very moment the limit is reached. In that cycle the completion must win over the abort. The bench gets there by having its memory model hold cam_mc_n high for exactly wait_limit wait cycles, counted from the write phase, so that the release lands on the limit cycle. It also raises host_req in the middle of a wait to show that the request is ignored. Finally, it holds host_req high across two accesses to show back-to-back acceptance.

// File: rtl/cam_match_pkg.sv
package cam_match_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_READ,
        ST_DONE
    } phase_t;

    typedef struct packed {
        logic start_n;
        logic oe_n;
        logic bus_en;
    } pin_drive_t;

    function automatic pin_drive_t drive_for(phase_t p);
        pin_drive_t d;
        d.start_n = (p != ST_WRITE);
        d.oe_n    = (p != ST_READ);
        d.bus_en  = (p == ST_WRITE);
        return d;
    endfunction

endpackage

// File: rtl/cam_wait_timer.sv
module cam_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/cam_match_fsm.sv
module cam_match_fsm
    import cam_match_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   mc_n,
    input  logic   expired,
    output phase_t phase,
    output logic   take_key,
    output logic   take_result,
    output logic   abort
);
    phase_t phase_q, phase_d;

    always_comb begin
        phase_d     = phase_q;
        take_key    = 1'b0;
        take_result = 1'b0;
        abort       = 1'b0;
        unique case (phase_q)
            ST_IDLE: begin
                if (req) begin
                    take_key = 1'b1;
                    phase_d  = ST_WRITE;
                end
            end
            ST_WRITE: phase_d = ST_WAIT;
            ST_WAIT: begin
                if (!mc_n) begin
                    phase_d = ST_READ;
                end else if (expired) begin
                    abort   = 1'b1;
                    phase_d = ST_DONE;
                end
            end
            ST_READ: begin
                take_result = 1'b1;
                phase_d     = ST_DONE;
            end
            ST_DONE: phase_d = ST_IDLE;
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= ST_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/cam_result_reg.sv
module cam_result_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_key,
    input  logic [DATA_W-1:0] key_in,
    input  logic              take_result,
    input  logic              ms_n,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              abort,
    output logic [DATA_W-1:0] key_q,
    output logic [DATA_W-1:0] result_q,
    output logic              err_q
);
    localparam logic [DATA_W-1:0] ABORT_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= '0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (take_key) key_q <= key_in;
            if (take_result) begin
                result_q <= {ms_n, dq_in[DATA_W-2:0]};
                err_q    <= 1'b0;
            end else if (abort) begin
                result_q <= ABORT_WORD;
                err_q    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_match_ctrl.sv
module cam_match_ctrl
    import cam_match_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [DATA_W-1:0] host_key,
    input  logic [CNT_W-1:0]  wait_limit,
    output logic              host_ready,
    output logic              host_done,
    output logic              host_err,
    output logic [DATA_W-1:0] host_result,
    output logic [DATA_W-1:0] cam_dq_out,
    output logic              cam_dq_oe,
    input  logic [DATA_W-1:0] cam_dq_in,
    output logic              cam_start_n,
    output logic              cam_oe_n,
    input  logic              cam_mc_n,
    input  logic              cam_ms_n
);
    phase_t      phase;
    pin_drive_t  drv;
    logic        take_key, take_result, abort, expired, err_q;
    logic [DATA_W-1:0] key_q;

    cam_match_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (host_req),
        .mc_n        (cam_mc_n),
        .expired     (expired),
        .phase       (phase),
        .take_key    (take_key),
        .take_result (take_result),
        .abort       (abort)
    );

    cam_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (phase == ST_WAIT),
        .limit   (wait_limit),
        .expired (expired)
    );

    cam_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .take_key    (take_key),
        .key_in      (host_key),
        .take_result (take_result),
        .ms_n        (cam_ms_n),
        .dq_in       (cam_dq_in),
        .abort       (abort),
        .key_q       (key_q),
        .result_q    (host_result),
        .err_q       (err_q)
    );

    assign drv         = drive_for(phase);
    assign cam_start_n = drv.start_n;
    assign cam_oe_n    = drv.oe_n;
    assign cam_dq_oe   = drv.bus_en;
    assign cam_dq_out  = drv.bus_en ? key_q : '0;
    assign host_ready  = (phase == ST_IDLE);
    assign host_done   = (phase == ST_DONE);
    assign host_err    = host_done && err_q;
endmodule

// File: rtl/cam_match_chk.sv
module cam_match_chk (
    input logic clk,
    input logic rst,
    input logic host_ready,
    input logic host_done,
    input logic host_err,
    input logic cam_dq_oe,
    input logic cam_start_n,
    input logic cam_oe_n,
    input logic cam_mc_n
);
    // R3
    bus_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(cam_dq_oe && !cam_oe_n));

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !cam_start_n |=> cam_start_n);

    // R2
    start_with_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !cam_start_n |-> cam_dq_oe);

    // R5
    oe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !cam_oe_n |=> cam_oe_n);

    // R5
    read_after_complete_chk: assert property (@(posedge clk) disable iff (rst)
        !cam_oe_n |-> $past(!cam_mc_n));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_done |=> (!host_done && host_ready));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        host_err |-> host_done);

    // R4
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !cam_start_n |-> !host_ready);
endmodule

bind cam_match_ctrl cam_match_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_ready  (host_ready),
    .host_done   (host_done),
    .host_err    (host_err),
    .cam_dq_oe   (cam_dq_oe),
    .cam_start_n (cam_start_n),
    .cam_oe_n    (cam_oe_n),
    .cam_mc_n    (cam_mc_n)
);

// File: tb/tb_cam_match_ctrl.sv
module tb_cam_match_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic [31:0] host_key = '0;
    logic [15:0] wait_limit = 16'd10;
    logic        host_ready, host_done, host_err;
    logic [31:0] host_result, cam_dq_out, cam_dq_in = '0;
    logic        cam_dq_oe, cam_start_n, cam_oe_n;
    logic        cam_mc_n = 1'b1;
    logic        cam_ms_n = 1'b1;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int strobes = 0;
    int hold = 0;

    // reference model
    int          mstate = 0;
    int          mwait = 0;
    logic [31:0] mkey = '0;
    logic [31:0] mres = '0;
    logic        merr = 1'b0;
    logic        seen_done = 1'b0;
    logic        seen_err = 1'b0;
    logic [31:0] seen_res = '0;

    always #4 clk = ~clk;

    cam_match_ctrl dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_key(host_key),
        .wait_limit(wait_limit), .host_ready(host_ready), .host_done(host_done),
        .host_err(host_err), .host_result(host_result), .cam_dq_out(cam_dq_out),
        .cam_dq_oe(cam_dq_oe), .cam_dq_in(cam_dq_in), .cam_start_n(cam_start_n),
        .cam_oe_n(cam_oe_n), .cam_mc_n(cam_mc_n), .cam_ms_n(cam_ms_n)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mstate = 0; mwait = 0; mkey = '0; mres = '0; merr = 1'b0;
        end else begin
            case (mstate)
                0: if (host_req) begin mkey = host_key; mstate = 1; end
                1: begin mstate = 2; mwait = 0; end
                2: begin
                    if (!cam_mc_n) mstate = 3;
                    else if (mwait >= int'(wait_limit)) begin
                        mres = 32'h8000_0000; merr = 1'b1; mstate = 4;
                    end else mwait++;
                end
                3: begin mres = {cam_ms_n, cam_dq_in[30:0]}; merr = 1'b0; mstate = 4; end
                default: mstate = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(host_ready == (mstate == 0), "R4 ready", 32'(host_ready), 32'(mstate == 0));
            chk(cam_start_n == (mstate != 1), "R2 start strobe", 32'(cam_start_n), 32'(mstate != 1));
            chk(cam_dq_oe == (mstate == 1), "R3 bus enable", 32'(cam_dq_oe), 32'(mstate == 1));
            if (mstate == 1) chk(cam_dq_out == mkey, "R2 key on bus", cam_dq_out, mkey);
            chk(cam_oe_n == (mstate != 3), "R5 output enable", 32'(cam_oe_n), 32'(mstate != 3));
            chk(host_done == (mstate == 4), "R7 done", 32'(host_done), 32'(mstate == 4));
            chk(host_err == ((mstate == 4) && merr), "R8 err", 32'(host_err), 32'((mstate == 4) && merr));
            chk(host_result == mres, "R6 result", host_result, mres);
            if (!cam_start_n) strobes++;
            if (host_done) begin
                seen_done = 1'b1; seen_err = host_err; seen_res = host_result;
            end
        end
        // memory model: match-complete stays high for hold wait cycles
        cam_mc_n = (mstate == 2) ? (mwait < hold) : 1'b1;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle_after_done();
        seen_done = 1'b0;
        while (!seen_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] key, input int h, input logic ms,
                          input logic [31:0] dq, input logic [15:0] lim);
        @(negedge clk);
        hold = h; cam_ms_n = ms; cam_dq_in = dq; wait_limit = lim;
        host_key = key; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        wait_idle_after_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(host_ready && !host_done && !host_err && cam_start_n && cam_oe_n && !cam_dq_oe,
            "R1 reset controls", {26'd0, host_ready, host_done, host_err, cam_start_n, cam_oe_n, cam_dq_oe}, 32'b100110);
        chk(host_result == 32'h0, "R1 reset result", host_result, 32'h0);

        // hit after a three-cycle search
        access(32'h1234_5678, 3, 1'b0, 32'h8ABC_DEF0, 16'd10);
        chk(seen_res == 32'h0ABC_DEF0 && !seen_err, "R6 hit word", seen_res, 32'h0ABC_DEF0);

        // miss with immediate completion
        access(32'hCAFE_0001, 0, 1'b1, 32'h7FFF_0001, 16'd10);
        chk(seen_res == 32'hFFFF_0001, "R6 miss word", seen_res, 32'hFFFF_0001);

        // R11 result holds while idle
        repeat (5) @(negedge clk);
        chk(host_result == 32'hFFFF_0001, "R11 result hold", host_result, 32'hFFFF_0001);

        // R8 timeout
        access(32'hDEAD_BEEF, 1000, 1'b0, 32'h1111_1111, 16'd3);
        chk(seen_err && seen_res == 32'h8000_0000, "R8 timeout word", seen_res, 32'h8000_0000);

        // R10 completion in the limit cycle wins
        access(32'h0F0F_0F0F, 2, 1'b0, 32'h2222_2222, 16'd2);
        chk(!seen_err && seen_res == 32'h2222_2222, "R10 tie read", seen_res, 32'h2222_2222);

        // R9 request while busy is ignored
        strobes = 0;
        @(negedge clk);
        hold = 6; cam_ms_n = 1'b0; cam_dq_in = 32'h3333_3333; wait_limit = 16'd20;
        host_key = 32'hAAAA_0001; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        repeat (2) @(negedge clk);
        host_key = 32'hBBBB_0002; host_req = 1'b1;
        repeat (3) @(negedge clk);
        host_req = 1'b0;
        wait_idle_after_done();
        repeat (3) @(negedge clk);
        chk(strobes == 1, "R9 single strobe", 32'(strobes), 32'd1);
        chk(host_ready, "R9 idle after busy req", 32'(host_ready), 32'd1);

        // back-to-back: request held high across two accesses
        strobes = 0;
        hold = 1; cam_ms_n = 1'b1; cam_dq_in = 32'h0000_0044; wait_limit = 16'd8;
        host_key = 32'h5555_5555; host_req = 1'b1;
        wait_idle_after_done();
        host_req = 1'b0;
        wait_idle_after_done();
        chk(strobes == 2, "R2 back-to-back strobes", 32'(strobes), 32'd2);
        chk(seen_res == 32'h8000_0044, "R6 back-to-back word", seen_res, 32'h8000_0044);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule